// File: doc/BRIEF.md
# CRT Raster Timing Generator

This block is the character-clocked timing core of a CRT display controller. A character counter steps every clock and wraps at the programmed line length. At each line end a raster counter steps inside the current character row, and a row counter steps inside the frame. After the last row, an optional run of extra raster lines pads the frame before it restarts. From this state the block produces horizontal and vertical sync, a display-enable strobe, a refresh-memory address for the character store and a raster address for the character generator.

All programming values are static input ports. They are sampled continuously and are meant to change only while reset is held. Totals are written as the count minus one. Sync widths are 4-bit nibbles in which zero stands for sixteen. A mode input delays display enable by one character clock, so that it lines up with a pipelined character fetch.

Top module: `crt_raster_gen`

## Requirements
- R1: A scan line lasts `h_total + 1` clock cycles; the character position runs from 0 to `h_total` and then returns to 0.
- R2: `ra` counts raster lines 0 to `raster_max` inside each character row, changes only on the clock that ends a line, and never exceeds `raster_max` outside the padding lines.
- R3: A frame lasts `(v_total + 1) * (raster_max + 1) + v_adjust` lines; during the `v_adjust` padding lines `ra` counts 0 to `v_adjust - 1` and display enable stays low.
- R4: `hsync` goes high in the cycle whose character position equals `h_sync_pos` and stays high for N cycles, where N is `sync_widths[3:0]` and the value 0 means 16; the pulse may run across the line end.
- R5: `vsync` goes high for the whole of raster line 0 of row `v_sync_pos` (not in padding) and stays high for M whole lines, where M is `sync_widths[7:4]` and the value 0 means 16; it changes only at line boundaries.
- R6: With `de_skew` low, `de` is high when the character position is below `h_disp`, the row index is below `v_disp` and the line is not a padding line. With `de_skew` high, `de` shows that same condition one clock later.
- R7: `ma` equals the current row's base address plus the character position, modulo 2^14, so it steps by one on every clock within a line.
- R8: The row base reloads to `start_addr` at frame start and advances by `h_disp` after the last raster line of each character row.
- R9: After reset, the first cycle is character 0 of raster 0 of row 0: `ma` = `start_addr`, `ra` = 0, and `de` is low when `de_skew` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| h_total | input | 8 | Characters per line minus one |
| h_disp | input | 8 | Displayed characters per line |
| h_sync_pos | input | 8 | Character position where hsync starts |
| sync_widths | input | 8 | [3:0] hsync width in characters, [7:4] vsync width in lines; 0 means 16 |
| v_total | input | 7 | Character rows per frame minus one |
| v_adjust | input | 5 | Extra raster lines at frame end |
| v_disp | input | 7 | Displayed character rows |
| v_sync_pos | input | 7 | Row whose raster 0 starts vsync |
| raster_max | input | 5 | Raster lines per row minus one |
| de_skew | input | 1 | Delay display enable by one character |
| start_addr | input | 14 | Refresh address of the first displayed character |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| ma | output | 14 | Refresh memory address |
| ra | output | 5 | Raster address within the row |

## Verification
The hardest cases to reach are sync pulses that outlive their own period or boundary: a 16-character hsync that wraps past the line end, and a 16-line vsync that spans several rows. Next to these come the frame boundary with and without padding lines, and the address wrap past 14 bits. The bench drives three programmings: one with short padding, one with both sync widths coded as zero, a start address just below the top of the address space and skew enabled, and one with single-line rows, maximum padding and syncs at position zero. It runs each for three whole frames against a closed-form model that works every output out from the clock count alone.

// File: rtl/crt_raster_pkg.sv
package crt_raster_pkg;

    localparam int SYNC_NIB = 4;

    // Pulse length coded in a nibble; zero stands for the longest pulse.
    function automatic logic [SYNC_NIB:0] sync_len(input logic [SYNC_NIB-1:0] nib);
        return (nib == '0) ? (SYNC_NIB+1)'(1 << SYNC_NIB) : {1'b0, nib};
    endfunction

    // Countdown preload for a pulse that is active in its start cycle.
    function automatic logic [SYNC_NIB-1:0] sync_preload(input logic [SYNC_NIB-1:0] nib);
        logic [SYNC_NIB:0] len;
        len = sync_len(nib);
        return SYNC_NIB'(len - 1'b1);
    endfunction

    typedef enum logic {
        PH_ROWS   = 1'b0,
        PH_ADJUST = 1'b1
    } v_phase_e;

endpackage

// File: rtl/crt_hcount.sv
module crt_hcount
    import crt_raster_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HW-1:0]       h_total,
    input  logic [HW-1:0]       h_disp,
    input  logic [HW-1:0]       h_sync_pos,
    input  logic [SYNC_NIB-1:0] h_width,
    output logic [HW-1:0]       hcount,
    output logic                line_end,
    output logic                h_active,
    output logic                hsync
);

    logic [SYNC_NIB-1:0] hs_left;
    logic                hs_start;

    assign line_end = (hcount == h_total);
    assign h_active = (hcount < h_disp);
    assign hs_start = (hcount == h_sync_pos);
    assign hsync    = hs_start || (hs_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hcount  <= '0;
            hs_left <= '0;
        end else begin
            hcount <= line_end ? '0 : hcount + 1'b1;
            if (hs_start) begin
                hs_left <= sync_preload(h_width);
            end else if (hs_left != '0) begin
                hs_left <= hs_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
    import crt_raster_pkg::*;
#(
    parameter int VW = 7,
    parameter int RW = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                line_end,
    input  logic [VW-1:0]       v_total,
    input  logic [RW-1:0]       v_adjust,
    input  logic [VW-1:0]       v_disp,
    input  logic [VW-1:0]       v_sync_pos,
    input  logic [SYNC_NIB-1:0] v_width,
    input  logic [RW-1:0]       raster_max,
    output logic [RW-1:0]       raster,
    output logic                in_adj,
    output logic                row_end,
    output logic                frame_end,
    output logic                v_active,
    output logic                vsync
);

    v_phase_e            phase;
    logic [VW-1:0]       row;
    logic [SYNC_NIB-1:0] vs_left;
    logic                last_raster;
    logic                vs_start;

    assign in_adj      = (phase == PH_ADJUST);
    assign last_raster = (raster == raster_max);
    assign row_end     = line_end && !in_adj && last_raster;
    assign frame_end   = line_end && (in_adj ? (raster == v_adjust - 1'b1)
                                             : (last_raster && row == v_total && v_adjust == '0));
    assign v_active    = !in_adj && (row < v_disp);
    assign vs_start    = !in_adj && (raster == '0) && (row == v_sync_pos);
    assign vsync       = vs_start || (vs_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_ROWS;
            row     <= '0;
            raster  <= '0;
            vs_left <= '0;
        end else if (line_end) begin
            if (vs_start) begin
                vs_left <= sync_preload(v_width);
            end else if (vs_left != '0) begin
                vs_left <= vs_left - 1'b1;
            end

            if (frame_end) begin
                phase  <= PH_ROWS;
                row    <= '0;
                raster <= '0;
            end else if (in_adj || !last_raster) begin
                raster <= raster + 1'b1;
            end else begin
                raster <= '0;
                if (row == v_total) begin
                    phase <= PH_ADJUST;
                end else begin
                    row <= row + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/crt_addr.sv
module crt_addr #(
    parameter int HW = 8,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] hcount,
    input  logic [HW-1:0] h_disp,
    input  logic [AW-1:0] start_addr,
    input  logic          row_end,
    input  logic          frame_end,
    output logic [AW-1:0] ma
);

    logic [AW-1:0] row_base;

    assign ma = row_base + AW'(hcount);

    always_ff @(posedge clk) begin
        if (rst || frame_end) begin
            row_base <= start_addr;
        end else if (row_end) begin
            row_base <= row_base + AW'(h_disp);
        end
    end

endmodule

// File: rtl/crt_raster_gen.sv
module crt_raster_gen
    import crt_raster_pkg::*;
#(
    parameter int HW = 8,
    parameter int VW = 7,
    parameter int RW = 5,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h_total,
    input  logic [HW-1:0] h_disp,
    input  logic [HW-1:0] h_sync_pos,
    input  logic [7:0]    sync_widths,
    input  logic [VW-1:0] v_total,
    input  logic [RW-1:0] v_adjust,
    input  logic [VW-1:0] v_disp,
    input  logic [VW-1:0] v_sync_pos,
    input  logic [RW-1:0] raster_max,
    input  logic          de_skew,
    input  logic [AW-1:0] start_addr,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [AW-1:0] ma,
    output logic [RW-1:0] ra
);

    logic [HW-1:0] hcount;
    logic          line_end;
    logic          h_active;
    logic          in_adj;
    logic          row_end;
    logic          frame_end;
    logic          v_active;
    logic          de_now;
    logic          de_late;

    crt_hcount #(.HW(HW)) u_h (
        .clk        (clk),
        .rst        (rst),
        .h_total    (h_total),
        .h_disp     (h_disp),
        .h_sync_pos (h_sync_pos),
        .h_width    (sync_widths[SYNC_NIB-1:0]),
        .hcount     (hcount),
        .line_end   (line_end),
        .h_active   (h_active),
        .hsync      (hsync)
    );

    crt_vcount #(.VW(VW), .RW(RW)) u_v (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_end),
        .v_total    (v_total),
        .v_adjust   (v_adjust),
        .v_disp     (v_disp),
        .v_sync_pos (v_sync_pos),
        .v_width    (sync_widths[2*SYNC_NIB-1:SYNC_NIB]),
        .raster_max (raster_max),
        .raster     (ra),
        .in_adj     (in_adj),
        .row_end    (row_end),
        .frame_end  (frame_end),
        .v_active   (v_active),
        .vsync      (vsync)
    );

    crt_addr #(.HW(HW), .AW(AW)) u_a (
        .clk        (clk),
        .rst        (rst),
        .hcount     (hcount),
        .h_disp     (h_disp),
        .start_addr (start_addr),
        .row_end    (row_end),
        .frame_end  (frame_end),
        .ma         (ma)
    );

    assign de_now = h_active && v_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            de_late <= 1'b0;
        end else begin
            de_late <= de_now;
        end
    end

    assign de = de_skew ? de_late : de_now;

endmodule

// File: rtl/crt_raster_chk.sv
module crt_raster_chk #(
    parameter int RW = 5,
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          line_end,
    input logic          in_adj,
    input logic          frame_end,
    input logic          vsync,
    input logic [RW-1:0] ra,
    input logic [RW-1:0] raster_max,
    input logic [RW-1:0] v_adjust,
    input logic [AW-1:0] ma,
    input logic [AW-1:0] start_addr
);

    p_ra_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(ra));

    p_ra_max_r2: assert property (@(posedge clk) disable iff (rst)
        !in_adj |-> (ra <= raster_max));

    p_adj_range_r3: assert property (@(posedge clk) disable iff (rst)
        in_adj |-> (ra < v_adjust));

    p_vsync_line_r5: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(vsync));

    p_ma_step_r7: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (ma == AW'($past(ma) + 1'b1)));

    p_frame_reload_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (ma == start_addr));

endmodule

bind crt_raster_gen crt_raster_chk #(.RW(RW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_end   (line_end),
    .in_adj     (in_adj),
    .frame_end  (frame_end),
    .vsync      (vsync),
    .ra         (ra),
    .raster_max (raster_max),
    .v_adjust   (v_adjust),
    .ma         (ma),
    .start_addr (start_addr)
);

// File: tb/test_crt_raster_gen.sv
`timescale 1ns/100ps
module test_crt_raster_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  h_total, h_disp, h_sync_pos, sync_widths;
    logic [6:0]  v_total, v_disp, v_sync_pos;
    logic [4:0]  v_adjust, raster_max;
    logic        de_skew;
    logic [13:0] start_addr;
    logic        hsync, vsync, de;
    logic [13:0] ma;
    logic [4:0]  ra;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    crt_raster_gen i_crt_raster_gen (
        .clk(clk), .rst(rst), .h_total(h_total), .h_disp(h_disp),
        .h_sync_pos(h_sync_pos), .sync_widths(sync_widths), .v_total(v_total),
        .v_adjust(v_adjust), .v_disp(v_disp), .v_sync_pos(v_sync_pos),
        .raster_max(raster_max), .de_skew(de_skew), .start_addr(start_addr),
        .hsync(hsync), .vsync(vsync), .de(de), .ma(ma), .ra(ra)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Closed-form reference: everything follows from the clock count t.
    function automatic int hlen();  return int'(h_total) + 1; endfunction
    function automatic int rlen();  return int'(raster_max) + 1; endfunction
    function automatic int body();  return (int'(v_total) + 1) * rlen(); endfunction
    function automatic int flen();  return body() + int'(v_adjust); endfunction
    function automatic int wid(input int nib); return (nib == 0) ? 16 : nib; endfunction

    function automatic bit is_vs_line(input int line);
        int fl = line % flen();
        return (fl < body()) && (fl % rlen() == 0) && (fl / rlen() == int'(v_sync_pos));
    endfunction

    function automatic bit de_raw(input int t);
        int fl = (t / hlen()) % flen();
        int hc = t % hlen();
        return (fl < body()) && (hc < int'(h_disp)) && (fl / rlen() < int'(v_disp));
    endfunction

    task automatic model(input int t, output bit m_hs, output bit m_vs, output bit m_de,
                         output int m_ma, output int m_ra);
        int hc = t % hlen();
        int line = t / hlen();
        int fl = line % flen();
        int row_idx;
        m_hs = 0;
        for (int k = 0; k < wid(int'(sync_widths[3:0])); k++)
            if (t - k >= 0 && ((t - k) % hlen()) == int'(h_sync_pos)) m_hs = 1;
        m_vs = 0;
        for (int k = 0; k < wid(int'(sync_widths[7:4])); k++)
            if (line - k >= 0 && is_vs_line(line - k)) m_vs = 1;
        if (de_skew) m_de = (t == 0) ? 1'b0 : de_raw(t - 1);
        else         m_de = de_raw(t);
        if (fl < body()) begin
            row_idx = fl / rlen();
            m_ra = fl % rlen();
        end else begin
            row_idx = int'(v_total) + 1;
            m_ra = fl - body();
        end
        m_ma = (int'(start_addr) + row_idx * int'(h_disp) + hc) % 16384;
    endtask

    task automatic run_cfg(input int frames);
        bit m_hs, m_vs, m_de;
        int m_ma, m_ra;
        int last_hs, last_vs;
        bit prev_hs, prev_vs;
        int total;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: state right after reset
        chk("R9", "ma after reset", int'(ma), int'(start_addr));
        chk("R9", "ra after reset", int'(ra), 0);
        if (de_skew) chk("R9", "de after reset with skew", int'(de), 0);
        last_hs = -1; last_vs = -1; prev_hs = 0; prev_vs = 0;
        total = frames * flen() * hlen();
        for (int t = 0; t < total; t++) begin
            model(t, m_hs, m_vs, m_de, m_ma, m_ra);
            chk("R4", "hsync", int'(hsync), int'(m_hs));
            chk("R5", "vsync", int'(vsync), int'(m_vs));
            chk("R6", "de", int'(de), int'(m_de));
            chk("R7_R8", "ma", int'(ma), m_ma);
            chk("R2_R3", "ra", int'(ra), m_ra);
            if (hsync && !prev_hs) begin
                if (last_hs >= 0) chk("R1", "hsync period", t - last_hs, hlen());
                last_hs = t;
            end
            if (vsync && !prev_vs) begin
                if (last_vs >= 0) chk("R3", "frame period", t - last_vs, flen() * hlen());
                last_vs = t;
            end
            prev_hs = hsync;
            prev_vs = vsync;
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        // Short rows with padding lines, no skew
        h_total = 8'd9;  h_disp = 8'd6;  h_sync_pos = 8'd7; sync_widths = 8'h23;
        v_total = 7'd4;  v_adjust = 5'd2; v_disp = 7'd3; v_sync_pos = 7'd3;
        raster_max = 5'd2; de_skew = 1'b0; start_addr = 14'h0100;
        run_cfg(3);
        // Both widths coded as 16, address wrap, skew, no padding
        h_total = 8'd19; h_disp = 8'd12; h_sync_pos = 8'd15; sync_widths = 8'h00;
        v_total = 7'd3;  v_adjust = 5'd0; v_disp = 7'd2; v_sync_pos = 7'd2;
        raster_max = 5'd7; de_skew = 1'b1; start_addr = 14'h3FF0;
        run_cfg(3);
        // Single-line rows, maximum padding, syncs at position zero
        h_total = 8'd7;  h_disp = 8'd8;  h_sync_pos = 8'd0; sync_widths = 8'h11;
        v_total = 7'd9;  v_adjust = 5'd31; v_disp = 7'd12; v_sync_pos = 7'd0;
        raster_max = 5'd0; de_skew = 1'b0; start_addr = 14'h2000;
        run_cfg(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule